// File: doc/BRIEF.md
# Linked-list process run queue

This block keeps the queue of processes that are ready to run and decides which one runs next. A process is known only by its workspace address. The block holds a small word-addressed workspace memory. Each workspace keeps its forward link at offset 0 and its saved instruction pointer at offset 1. Only two registers, a head pointer and a tail pointer, sit outside that memory, so the queue costs no storage per entry beyond the workspace words. A process that is waiting for something is simply not on the chain and uses no scheduling time.

Commands arrive one at a time over a valid/ready handshake. The commands are:

- start a process with a given instruction pointer;
- resume a process from the pointer saved in its workspace;
- deschedule the running process and save its pointer;
- end a component of a parallel construct against a join counter in workspace memory;
- store a word, which sets up such a counter before the components are started.

The block presents the running workspace and its instruction pointer. When nothing is left to run, it raises an idle flag. The evaluation stack is never saved, because it is not part of this block.

Top module: `runq_sched`

## Requirements
- R1: After a synchronous active-low reset, cmd_ready is 1, run_valid is 0, idle is 1, and the queue is empty.
- R2: A command is taken on a clock edge where cmd_valid and cmd_ready are both high. For start (op 0), end (op 2), store (op 3) and resume (op 4), cmd_ready stays low in the following cycle and stays low until every memory access of that command is done.
- R3: Start and resume append the workspace at the tail of the queue. Processes are dispatched strictly in the order they were appended. A link value of all ones marks the end of the chain, and a start never changes the running process.
- R4: When no process is running and the queue becomes non-empty, the head entry is dispatched without any further command.
- R5: Deschedule (op 1) writes cmd_data into word run_wptr+1 of the running workspace. It then dispatches the head of the queue, whose run_ip is the pointer stored in that workspace.
- R6: If the queue is empty when a dispatch is attempted, idle goes to 1 and run_valid goes to 0.
- R7: Deschedule while no process is running has no effect. idle stays 1 and the queue is unchanged.
- R8: Resume (op 4) enqueues cmd_wptr without writing its pointer word. When it is dispatched, it runs from the pointer last saved for it.
- R9: Store (op 3) writes cmd_data into memory word cmd_wptr. This word can later serve as a join counter.
- R10: End (op 2) decrements the word at cmd_wptr. If the result is non-zero, the running process is dropped without saving its pointer and the head of the queue is dispatched.
- R11: End with a decremented result of zero leaves the running process and its pointer unchanged.
- R12: Op codes 5 to 7 are accepted and ignored. Outputs and the queue are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | 0 start, 1 deschedule, 2 end, 3 store, 4 resume |
| cmd_wptr | input | ADDR_W | Workspace address or counter address |
| cmd_data | input | DATA_W | Instruction pointer, saved pointer or stored word |
| run_valid | output | 1 | A process is running |
| run_wptr | output | ADDR_W | Workspace of the running process |
| run_ip | output | DATA_W | Instruction pointer to resume it at |
| idle | output | 1 | Queue found empty at the last dispatch |

## Verification
The assertions assume several things about the inputs:

- Commands are presented only through the handshake.
- No workspace is appended while it is already queued or running.
- Workspaces lie far enough below the top of memory that both of their words are addressable.
- End is applied only to a counter that was stored first.

The stimulus keeps to these rules by using distinct workspace addresses below 0x60 and counters at 0x80 and above, and by re-queueing a process only after it has left the queue.

// File: rtl/runq_pkg.sv
// Shared command and state encodings for the run queue scheduler.
// Assumes: op codes are fixed by the command interface, states are private.
package runq_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_DESCHED = 3'd1,
        OP_ENDP    = 3'd2,
        OP_STORE   = 3'd3,
        OP_RESUME  = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_READY,
        S_ST_IP,
        S_ST_LINK,
        S_ST_TAIL,
        S_SAVE_IP,
        S_STORE,
        S_END_RD,
        S_END_WR,
        S_POP,
        S_POP_L,
        S_POP_I
    } st_e;

endpackage

// File: rtl/runq_wsmem.sv
// Single-port workspace memory with one cycle read latency.
// Assumes: one access per cycle; a write does not update rdata.
module runq_wsmem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write or registered read on an enabled cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                rdata <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/runq_join.sv
// Join counter arithmetic: decrement and test the result for zero.
// Assumes: the counter was initialised to a non-zero component count.
module runq_join #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cnt,
    output logic [DATA_W-1:0] dec,
    output logic              last
);
    // One component finished; last is set when none remain.
    always_comb begin
        dec  = cnt - DATA_W'(1);
        last = (dec == '0);
    end
endmodule

// File: rtl/runq_ctrl.sv
// Sequencer for the run queue: keeps head/tail registers, threads links
// through workspace memory, and dispatches the running process.
// Assumes: ADDR_W < DATA_W; a workspace is never queued twice at once.
module runq_ctrl
    import runq_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int LINK_OFS = 0,
    parameter int IP_OFS   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_wptr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              run_valid,
    output logic [ADDR_W-1:0] run_wptr,
    output logic [DATA_W-1:0] run_ip,
    output logic              idle,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] join_cnt,
    input  logic [DATA_W-1:0] join_dec,
    input  logic              join_last
);
    localparam logic [ADDR_W-1:0] NULL_PTR = '1;
    localparam logic [ADDR_W-1:0] LINK_A   = ADDR_W'(LINK_OFS);
    localparam logic [ADDR_W-1:0] IP_A     = ADDR_W'(IP_OFS);

    st_e               st;
    logic [ADDR_W-1:0] c_wptr;
    logic [DATA_W-1:0] c_data;
    logic [ADDR_W-1:0] front;
    logic [ADDR_W-1:0] back;
    logic [ADDR_W-1:0] nxt_link;

    assign cmd_ready = (st == S_READY);
    assign join_cnt  = mem_rdata;

    // Memory port drive: one access per state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (st)
            S_ST_IP: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = c_wptr + IP_A; mem_wdata = c_data;
            end
            S_ST_LINK: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = c_wptr + LINK_A; mem_wdata = DATA_W'(NULL_PTR);
            end
            S_ST_TAIL: begin
                mem_en = (back != NULL_PTR); mem_we = 1'b1;
                mem_addr = back + LINK_A; mem_wdata = DATA_W'(c_wptr);
            end
            S_SAVE_IP: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = run_wptr + IP_A; mem_wdata = c_data;
            end
            S_STORE: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = c_wptr; mem_wdata = c_data;
            end
            S_END_RD: begin
                mem_en = 1'b1; mem_addr = c_wptr;
            end
            S_END_WR: begin
                mem_en = 1'b1; mem_we = 1'b1;
                mem_addr = c_wptr; mem_wdata = join_dec;
            end
            S_POP: begin
                mem_en = (front != NULL_PTR); mem_addr = front + LINK_A;
            end
            S_POP_L: begin
                mem_en = 1'b1; mem_addr = front + IP_A;
            end
            default: begin
                mem_en = 1'b0;
            end
        endcase
    end

    // Command sequencing, queue pointers and dispatch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_READY;
            c_wptr    <= '0;
            c_data    <= '0;
            front     <= NULL_PTR;
            back      <= NULL_PTR;
            nxt_link  <= NULL_PTR;
            run_valid <= 1'b0;
            run_wptr  <= '0;
            run_ip    <= '0;
            idle      <= 1'b1;
        end else begin
            unique case (st)
                S_READY: begin
                    if (cmd_valid) begin
                        c_wptr <= cmd_wptr;
                        c_data <= cmd_data;
                        case (cmd_op)
                            OP_START:  st <= S_ST_IP;
                            OP_RESUME: st <= S_ST_LINK;
                            OP_ENDP:   st <= S_END_RD;
                            OP_STORE:  st <= S_STORE;
                            OP_DESCHED: begin
                                if (run_valid) begin
                                    run_valid <= 1'b0;
                                    st        <= S_SAVE_IP;
                                end
                            end
                            default: st <= S_READY;
                        endcase
                    end
                end
                S_ST_IP:   st <= S_ST_LINK;
                S_ST_LINK: st <= S_ST_TAIL;
                S_ST_TAIL: begin
                    if (back == NULL_PTR) begin
                        front <= c_wptr;
                    end
                    back <= c_wptr;
                    st   <= run_valid ? S_READY : S_POP;
                end
                S_SAVE_IP: st <= S_POP;
                S_STORE:   st <= S_READY;
                S_END_RD:  st <= S_END_WR;
                S_END_WR: begin
                    if (!join_last) begin
                        run_valid <= 1'b0;
                        st        <= S_POP;
                    end else begin
                        st <= S_READY;
                    end
                end
                S_POP: begin
                    if (front == NULL_PTR) begin
                        idle      <= 1'b1;
                        run_valid <= 1'b0;
                        st        <= S_READY;
                    end else begin
                        st <= S_POP_L;
                    end
                end
                S_POP_L: begin
                    nxt_link <= mem_rdata[ADDR_W-1:0];
                    st       <= S_POP_I;
                end
                S_POP_I: begin
                    run_ip    <= mem_rdata;
                    run_wptr  <= front;
                    run_valid <= 1'b1;
                    idle      <= 1'b0;
                    front     <= nxt_link;
                    if (nxt_link == NULL_PTR) begin
                        back <= NULL_PTR;
                    end
                    st <= S_READY;
                end
                default: st <= S_READY;
            endcase
        end
    end

    // R6: idle and a running process never coexist.
    p_idle_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !run_valid);

    // R2: a working command holds off the next one.
    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op == OP_START || cmd_op == OP_ENDP ||
         cmd_op == OP_STORE || cmd_op == OP_RESUME)) |=> !cmd_ready);

    // R3: head and tail are empty together.
    p_ends_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (front == NULL_PTR) == (back == NULL_PTR));

    // R5: a dispatched process is the former head.
    p_dispatch_front_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_valid) |-> (run_wptr == $past(front)));

    // R7: deschedule with nothing running leaves the queue alone.
    p_desched_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_DESCHED && !run_valid)
        |=> (!run_valid && $stable(front) && $stable(back)));

    // R11: the last component keeps running.
    p_join_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_END_WR && join_last && run_valid)
        |=> (run_valid && $stable(run_wptr) && $stable(run_ip)));
endmodule

// File: rtl/runq_sched.sv
// Top of the run queue scheduler: sequencer, workspace memory and join unit.
// Assumes: ADDR_W < DATA_W so a link fits in a workspace word.
module runq_sched #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int LINK_OFS = 0,
    parameter int IP_OFS   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_wptr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              run_valid,
    output logic [ADDR_W-1:0] run_wptr,
    output logic [DATA_W-1:0] run_ip,
    output logic              idle
);
    logic              mem_en;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] join_cnt;
    logic [DATA_W-1:0] join_dec;
    logic              join_last;

    runq_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .LINK_OFS(LINK_OFS), .IP_OFS(IP_OFS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_wptr(cmd_wptr), .cmd_data(cmd_data),
        .run_valid(run_valid), .run_wptr(run_wptr), .run_ip(run_ip), .idle(idle),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .join_cnt(join_cnt), .join_dec(join_dec), .join_last(join_last)
    );

    runq_wsmem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

    runq_join #(.DATA_W(DATA_W)) u_join (
        .cnt(join_cnt), .dec(join_dec), .last(join_last)
    );
endmodule

// File: tb/runq_sched_test.sv
// Directed bench for the run queue scheduler, one task per scenario.
module runq_sched_test;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_wptr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          run_valid;
    logic [AW-1:0] run_wptr;
    logic [DW-1:0] run_ip;
    logic          idle;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    runq_sched #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_wptr(cmd_wptr), .cmd_data(cmd_data),
        .run_valid(run_valid), .run_wptr(run_wptr), .run_ip(run_ip), .idle(idle)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected under 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_run(input string req, input logic [AW-1:0] w, input logic [DW-1:0] ip);
        chk(req, {31'd0, run_valid}, 32'd1);
        chk(req, {24'd0, run_wptr}, {24'd0, w});
        chk(req, {16'd0, run_ip}, {16'd0, ip});
    endtask

    task automatic chk_idle(input string req);
        chk(req, {31'd0, run_valid}, 32'd0);
        chk(req, {31'd0, idle}, 32'd1);
    endtask

    task automatic send(input logic [2:0] op, input logic [AW-1:0] w, input logic [DW-1:0] d);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_wptr = w; cmd_data = d;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready", {31'd0, cmd_ready}, 32'd1);
        chk_idle("R1 idle");
    endtask

    task automatic t_handshake();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_wptr = 8'h90; cmd_data = 16'h0007;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R2 ready low after take", {31'd0, cmd_ready}, 32'd0);
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic t_first_start();
        send(3'd0, 8'h10, 16'h0100);
        chk_run("R4 auto dispatch", 8'h10, 16'h0100);
        chk("R4 idle cleared", {31'd0, idle}, 32'd0);
    endtask

    task automatic t_fifo();
        send(3'd0, 8'h20, 16'h0200);
        send(3'd0, 8'h30, 16'h0300);
        chk_run("R3 start keeps current", 8'h10, 16'h0100);
        send(3'd1, 8'h00, 16'h0111);
        chk_run("R5 desched to head", 8'h20, 16'h0200);
        send(3'd1, 8'h00, 16'h0222);
        chk_run("R3 fifo second", 8'h30, 16'h0300);
        send(3'd1, 8'h00, 16'h0333);
        chk_idle("R6 empty dispatch");
    endtask

    task automatic t_ignore_and_resume();
        send(3'd1, 8'h00, 16'hBEEF);
        chk_idle("R7 desched idle ignored");
        send(3'd4, 8'h20, 16'h0000);
        chk_run("R8 resume saved ip", 8'h20, 16'h0222);
        send(3'd1, 8'h00, 16'h0444);
        chk_idle("R7 queue untouched");
    endtask

    task automatic t_unknown();
        send(3'd4, 8'h30, 16'h0000);
        chk_run("R8 resume second", 8'h30, 16'h0333);
        for (int k = 5; k < 8; k++) begin
            send(3'(k), 8'h40, 16'h5555);
            chk_run("R12 unknown op", 8'h30, 16'h0333);
        end
        send(3'd1, 8'h00, 16'h0334);
        chk_idle("R12 nothing enqueued");
    endtask

    task automatic t_join();
        send(3'd3, 8'h80, 16'd2);
        send(3'd4, 8'h10, 16'h0000);
        chk_run("R8 resume first", 8'h10, 16'h0111);
        send(3'd0, 8'h40, 16'h0400);
        send(3'd2, 8'h80, 16'h0000);
        chk_run("R10 nonzero drops current", 8'h40, 16'h0400);
        send(3'd2, 8'h80, 16'h0000);
        chk_run("R11 zero continues", 8'h40, 16'h0400);
        send(3'd1, 8'h00, 16'h0401);
        chk_idle("R10 dropped process not rerun");
    endtask

    task automatic t_store();
        send(3'd3, 8'h82, 16'd1);
        send(3'd0, 8'h50, 16'h0500);
        chk_run("R4 dispatch again", 8'h50, 16'h0500);
        send(3'd2, 8'h82, 16'h0000);
        chk_run("R9 stored count one", 8'h50, 16'h0500);
    endtask

    task automatic t_long_chain();
        for (int k = 0; k < 5; k++) begin
            send(3'd0, AW'(8'h08 + 2 * k), DW'(16'h0A00 + k));
        end
        for (int k = 0; k < 5; k++) begin
            send(3'd1, 8'h00, 16'h0000);
            chk_run("R3 chain order", AW'(8'h08 + 2 * k), DW'(16'h0A00 + k));
        end
        send(3'd1, 8'h00, 16'h0000);
        chk_idle("R6 chain drained");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_handshake();
        t_first_start();
        t_fifo();
        t_ignore_and_resume();
        t_unknown();
        t_join();
        t_store();
        t_long_chain();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule